// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves branches for a 24-bit processor core. For the instruction currently issued, it reports three things in the same cycle: whether the branch is taken, the new program counter, and how many cycles the branch costs. The branch kinds are conditional PC-relative jumps, unconditional PC-relative jumps, absolute jumps, and jumps whose target comes from a register (added to the PC, or used directly). The condition is one of ten tests on the Z, N, C and V flags, covering signed, unsigned and equality comparisons.

A short displacement or address can be widened by up to two 13-bit immediate-extension prefix words issued just before the branch. The unit collects these prefixes in an internal register. The next non-prefix instruction consumes them, and they are then discarded whether or not that branch is taken. A delayed-branch bit selects the shorter cycle cost of the delayed variant.

Top module: `brtgt`

## Requirements
- R1: Condition code `cond` selects the test applied to the flags. The codes are 0 gt = !Z&!(N^V), 1 ge = !(N^V), 2 lt = N^V, 3 le = Z|(N^V), 4 ugt = !Z&!C, 5 uge = !C, 6 ult = C, 7 ule = Z|C, 8 eq = Z and 9 ne = !Z. Codes 10 to 15 are never taken. The condition is used only by `form`=4.
- R2: A conditional branch (`form`=4) that is taken targets pc+2+D, where D depends on how many prefixes are held. With none, D is {imm[6:0],0} sign-extended from 8 bits. With one prefix P, D is {P,imm[6:0],0} sign-extended from 21 bits. With two prefixes P1 then P2, D is {P1[2:0],P2,imm[6:0],0}.
- R3: An unconditional relative jump (`form`=0) targets pc+2+D. With no prefix, D is {imm[9:0],0} sign-extended from 11 bits. With at least one prefix, D is {P,imm[9:0],0}, where P is the most recent prefix word; with two prefixes the first one is ignored.
- R4: An absolute jump (`form`=2) loads a value into the PC. With no prefix the value is imm[6:0] zero-extended. With one prefix P it is {P,imm[6:0]} sign-extended from 20 bits. With two prefixes P1 then P2 it is {P1[3:0],P2,imm[6:0]}.
- R5: A register-relative jump (`form`=1) targets pc+2+rb. A register-absolute jump (`form`=3) targets rb. Both ignore any held prefixes.
- R6: A conditional branch whose condition fails, and any `form` value from 5 to 7, gives taken=0 and target=pc+2.
- R7: A conditional branch costs 3 cycles when taken and 2 cycles when not taken if `dly`=0. It costs 2 cycles in either case if `dly`=1.
- R8: Forms 0 to 3 are always taken and cost 3 cycles, or 2 cycles if `dly`=1. A prefix instruction (`is_ext`=1) reports taken=0 and costs 1 cycle.
- R9: At most two prefixes are held. Further prefix words are ignored until a non-prefix instruction is issued.
- R10: Any non-prefix instruction that is issued empties the prefix register, whether it is taken or not.
- R11: After reset the prefix register is empty. While `issue`=0, taken and cycles are 0.
- R12: All target arithmetic is 24 bits wide and wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| is_ext | input | 1 | The presented instruction is an extension prefix |
| ext_imm | input | 13 | Immediate word of the prefix |
| form | input | 3 | 0 rel10, 1 reg-relative, 2 abs7, 3 reg-absolute, 4 conditional |
| cond | input | 4 | Condition code (see R1) |
| dly | input | 1 | Delayed-branch variant |
| imm | input | 10 | Instruction immediate; low 7 bits for forms 2 and 4 |
| rb | input | 24 | Register operand |
| pc | input | 24 | Address of the branch instruction |
| z_flag | input | 1 | Zero flag |
| n_flag | input | 1 | Negative flag |
| c_flag | input | 1 | Carry flag |
| v_flag | input | 1 | Overflow flag |
| taken | output | 1 | Branch is taken |
| target | output | 24 | Next PC |
| cycles | output | 2 | Cycle cost of this instruction |

## Verification
The taken flag, the target and the cycle count are combinational. They are valid in the same cycle in which an instruction is presented, so the bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. The prefix register changes only on the rising edge that ends a presented prefix or branch. For that reason every test that depends on held prefixes first completes those prefix cycles, then presents the branch on a later falling edge. The checks on clearing and on saturation observe the prefix state through the target of the following branch.

// File: rtl/brtgt.sv
module brtgt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic        is_ext,
  input  logic [12:0] ext_imm,
  input  logic [2:0]  form,
  input  logic [3:0]  cond,
  input  logic        dly,
  input  logic [9:0]  imm,
  input  logic [23:0] rb,
  input  logic [23:0] pc,
  input  logic        z_flag,
  input  logic        n_flag,
  input  logic        c_flag,
  input  logic        v_flag,
  output logic        taken,
  output logic [23:0] target,
  output logic [1:0]  cycles
);
  localparam logic [2:0] F_REL10  = 3'd0;
  localparam logic [2:0] F_REGREL = 3'd1;
  localparam logic [2:0] F_ABS7   = 3'd2;
  localparam logic [2:0] F_REGABS = 3'd3;
  localparam logic [2:0] F_COND   = 3'd4;

  logic [12:0] pfx0, pfx1;
  logic [1:0]  pfx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx0    <= '0;
      pfx1    <= '0;
      pfx_cnt <= 2'd0;
    end else if (issue) begin
      if (!is_ext) begin
        pfx_cnt <= 2'd0;
      end else if (pfx_cnt == 2'd0) begin
        pfx0    <= ext_imm;
        pfx_cnt <= 2'd1;
      end else if (pfx_cnt == 2'd1) begin
        pfx1    <= ext_imm;
        pfx_cnt <= 2'd2;
      end
    end
  end

  logic cond_ok;
  always_comb begin
    case (cond)
      4'd0:    cond_ok = !z_flag && !(n_flag ^ v_flag);
      4'd1:    cond_ok = !(n_flag ^ v_flag);
      4'd2:    cond_ok = n_flag ^ v_flag;
      4'd3:    cond_ok = z_flag || (n_flag ^ v_flag);
      4'd4:    cond_ok = !z_flag && !c_flag;
      4'd5:    cond_ok = !c_flag;
      4'd6:    cond_ok = c_flag;
      4'd7:    cond_ok = z_flag || c_flag;
      4'd8:    cond_ok = z_flag;
      4'd9:    cond_ok = !z_flag;
      default: cond_ok = 1'b0;
    endcase
  end

  wire [23:0] seq_pc = pc + 24'd2;
  wire [12:0] latest = (pfx_cnt == 2'd2) ? pfx1 : pfx0;

  logic [23:0] disp_c, disp_j, abs_v;
  always_comb begin
    case (pfx_cnt)
      2'd0:    disp_c = {{16{imm[6]}}, imm[6:0], 1'b0};
      2'd1:    disp_c = {{3{pfx0[12]}}, pfx0, imm[6:0], 1'b0};
      default: disp_c = {pfx0[2:0], pfx1, imm[6:0], 1'b0};
    endcase
    case (pfx_cnt)
      2'd0:    abs_v = {17'd0, imm[6:0]};
      2'd1:    abs_v = {{4{pfx0[12]}}, pfx0, imm[6:0]};
      default: abs_v = {pfx0[3:0], pfx1, imm[6:0]};
    endcase
    if (pfx_cnt == 2'd0) disp_j = {{13{imm[9]}}, imm[9:0], 1'b0};
    else                 disp_j = {latest, imm[9:0], 1'b0};
  end

  always_comb begin
    taken  = 1'b0;
    target = seq_pc;
    cycles = 2'd0;
    if (issue && is_ext) begin
      cycles = 2'd1;
    end else if (issue) begin
      cycles = dly ? 2'd2 : 2'd3;
      case (form)
        F_REL10:  begin taken = 1'b1; target = seq_pc + disp_j; end
        F_REGREL: begin taken = 1'b1; target = seq_pc + rb;     end
        F_ABS7:   begin taken = 1'b1; target = abs_v;           end
        F_REGABS: begin taken = 1'b1; target = rb;              end
        F_COND: begin
          taken = cond_ok;
          if (cond_ok) target = seq_pc + disp_c;
          else         cycles = 2'd2;
        end
        default: cycles = 2'd2;
      endcase
    end
  end
endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue,
  input logic        is_ext,
  input logic [2:0]  form,
  input logic        dly,
  input logic [23:0] pc,
  input logic        taken,
  input logic [23:0] target,
  input logic [1:0]  cycles,
  input logic [1:0]  pfx_cnt
);
  p_prefix_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_ext |-> cycles == 2'd1 && !taken);

  p_uncond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_ext && form <= 3'd3 |-> taken && cycles == (dly ? 2'd2 : 2'd3));

  p_cond_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_ext && form == 3'd4 |-> cycles == ((dly || !taken) ? 2'd2 : 2'd3));

  p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_ext && !taken |-> target == pc + 24'd2);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_ext |=> pfx_cnt == 2'd0);

  p_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt != 2'd3);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> !taken && cycles == 2'd0);
endmodule

bind brtgt brtgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .is_ext(is_ext), .form(form),
  .dly(dly), .pc(pc), .taken(taken), .target(target), .cycles(cycles),
  .pfx_cnt(pfx_cnt)
);

// File: tb/brtgt_tb.sv
`timescale 1ns/1ps
module brtgt_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 1'b0, is_ext = 1'b0, dly = 1'b0;
  logic [12:0] ext_imm = '0;
  logic [2:0] form = '0;
  logic [3:0] cond = '0;
  logic [9:0] imm = '0;
  logic [23:0] rb = '0, pc = '0;
  logic z_flag = 1'b0, n_flag = 1'b0, c_flag = 1'b0, v_flag = 1'b0;
  logic taken;
  logic [23:0] target;
  logic [1:0] cycles;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  brtgt u_dut (.*);

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_cond(input logic [3:0] c, input bit z, input bit n, input bit cy, input bit v);
    bit lt = (n != v);
    case (c)
      4'd0: return !z && !lt;
      4'd1: return !lt;
      4'd2: return lt;
      4'd3: return z || lt;
      4'd4: return !z && !cy;
      4'd5: return !cy;
      4'd6: return cy;
      4'd7: return z || cy;
      4'd8: return z;
      4'd9: return !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic push(input logic [12:0] w);
    @(negedge clk); issue = 1; is_ext = 1; ext_imm = w; #1;
    chk("R8 prefix cycles", {22'd0, cycles}, 24'd1);
    chk("R8 prefix not taken", {23'd0, taken}, 24'd0);
    @(posedge clk); #1; issue = 0; is_ext = 0;
  endtask

  task automatic br(input logic [2:0] f, input logic [3:0] c, input logic d,
                    input logic [9:0] im, input logic [23:0] r, input logic [23:0] p);
    @(negedge clk); issue = 1; is_ext = 0; form = f; cond = c; dly = d;
    imm = im; rb = r; pc = p; #1;
  endtask

  task automatic fin;
    @(posedge clk); #1; issue = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R11 taken in reset", {23'd0, taken}, 24'd0);
    chk("R11 cycles in reset", {22'd0, cycles}, 24'd0);
    @(negedge clk); rst_n = 1;
    br(3'd4, 4'd8, 0, 10'h005, 0, 24'h001000); z_flag = 1; #1;
    chk("R11 empty prefix after reset", target, 24'h00100C);
    fin();
    @(negedge clk); #1;
    chk("R11 idle taken", {23'd0, taken}, 24'd0);
  endtask

  task automatic t_conditions;
    for (int c = 0; c < 16; c++)
      for (int fl = 0; fl < 16; fl++) begin
        bit e;
        br(3'd4, 4'(c), 0, 10'h001, 0, 24'h000400);
        {z_flag, n_flag, c_flag, v_flag} = 4'(fl); #1;
        e = exp_cond(4'(c), fl[3], fl[2], fl[1], fl[0]);
        chk("R1 condition", {23'd0, taken}, {23'd0, e});
        chk("R7 cond cycles", {22'd0, cycles}, e ? 24'd3 : 24'd2);
        chk("R6 target", target, e ? 24'h000404 : 24'h000402);
        dly = 1; #1;
        chk("R7 delayed cycles", {22'd0, cycles}, 24'd2);
        fin();
      end
  endtask

  task automatic t_cond_target;
    z_flag = 1;
    br(3'd4, 4'd8, 0, 10'h07F, 0, 24'h001000); chk("R2 no prefix negative", target, 24'h001000); fin();
    push(13'h1FFF);
    br(3'd4, 4'd8, 0, 10'h000, 0, 24'h001000); chk("R2 one prefix negative", target, 24'h000F02); fin();
    push(13'h0001);
    br(3'd4, 4'd8, 0, 10'h001, 0, 24'h001000); chk("R2 one prefix", target, 24'h001104); fin();
    push(13'h0005); push(13'h0003);
    br(3'd4, 4'd8, 0, 10'h002, 0, 24'h001000); chk("R2 two prefixes", target, 24'hA01306); fin();
    push(13'h1FF8); push(13'h0000);
    br(3'd4, 4'd8, 0, 10'h000, 0, 24'h001000); chk("R2 first prefix high bits dropped", target, 24'h001002); fin();
  endtask

  task automatic t_rel10;
    br(3'd0, 0, 0, 10'h3FF, 0, 24'h000100); chk("R3 minus two", target, 24'h000100);
    chk("R8 jump cycles", {22'd0, cycles}, 24'd3); fin();
    br(3'd0, 0, 1, 10'h200, 0, 24'h000800); chk("R3 most negative", target, 24'h000402);
    chk("R8 delayed jump cycles", {22'd0, cycles}, 24'd2); fin();
    push(13'h1000);
    br(3'd0, 0, 0, 10'h001, 0, 24'h000100); chk("R3 one prefix", target, 24'h800104); fin();
    push(13'h0FFF); push(13'h0001);
    br(3'd0, 0, 0, 10'h000, 0, 24'h000100); chk("R3 two prefixes latest used", target, 24'h000902); fin();
  endtask

  task automatic t_abs7;
    br(3'd2, 0, 0, 10'h37F, 0, 24'h123456); chk("R4 zero extend", target, 24'h00007F);
    chk("R8 abs taken", {23'd0, taken}, 24'd1); fin();
    push(13'h1000);
    br(3'd2, 0, 0, 10'h001, 0, 24'h123456); chk("R4 one prefix sign", target, 24'hF80001); fin();
    push(13'h0ABC);
    br(3'd2, 0, 0, 10'h005, 0, 24'h123456); chk("R4 one prefix", target, 24'h055E05); fin();
    push(13'h001F); push(13'h0000);
    br(3'd2, 0, 0, 10'h012, 0, 24'h123456); chk("R4 two prefixes", target, 24'hF00012); fin();
  endtask

  task automatic t_reg;
    br(3'd1, 0, 0, 0, 24'h000100, 24'h000010); chk("R5 reg relative", target, 24'h000112); fin();
    br(3'd3, 0, 0, 0, 24'hABCDEF, 24'h000010); chk("R5 reg absolute", target, 24'hABCDEF); fin();
    push(13'h1234);
    br(3'd3, 0, 0, 0, 24'hABCDEF, 24'h000010); chk("R5 prefix ignored", target, 24'hABCDEF); fin();
    br(3'd2, 0, 0, 10'h001, 0, 0); chk("R10 cleared by reg jump", target, 24'h000001); fin();
    br(3'd5, 0, 0, 0, 24'h000100, 24'h000020);
    chk("R6 unused form taken", {23'd0, taken}, 24'd0);
    chk("R6 unused form target", target, 24'h000022); fin();
  endtask

  task automatic t_clear;
    push(13'h1000);
    z_flag = 0;
    br(3'd4, 4'd8, 0, 10'h000, 0, 24'h001000);
    chk("R10 not taken", {23'd0, taken}, 24'd0); fin();
    z_flag = 1;
    br(3'd4, 4'd8, 0, 10'h000, 0, 24'h001000); chk("R10 cleared after not taken", target, 24'h001002); fin();
  endtask

  task automatic t_saturate;
    push(13'h0001); push(13'h0002); push(13'h1FFF);
    z_flag = 1;
    br(3'd4, 4'd8, 0, 10'h000, 0, 24'h000000); chk("R9 third prefix ignored", target, 24'h200202); fin();
  endtask

  task automatic t_wrap;
    br(3'd1, 0, 0, 0, 24'h000004, 24'hFFFFFE); chk("R12 reg relative wrap", target, 24'h000004); fin();
    z_flag = 1;
    br(3'd4, 4'd8, 0, 10'h003, 0, 24'hFFFFFC); chk("R12 cond wrap", target, 24'h000004); fin();
  endtask

  initial begin
    t_reset();
    t_conditions();
    t_cond_target();
    t_rel10();
    t_abs7();
    t_reg();
    t_clear();
    t_saturate();
    t_wrap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule